// File: doc/BRIEF.md
# Two-Channel Event Timer with Periodic Comparators

This block is a memory-mapped event timer. A 64-bit up-counter advances by one on every clock while a global run bit is set. Two comparator channels watch that counter. Each channel can raise one interrupt pulse when the counter reaches its match value, or it can raise a pulse on every match and then move its match value forward by a programmed step. Software reaches every register through a plain 32-bit bus with separate read and write strobes, a byte address and write data. Read data is registered and appears on the cycle after the read strobe.

A periodic channel is loaded in three bus writes. The first write sets a self-clearing load-sequence flag in the channel configuration. The next write to the comparator low word sets the first match value. The write after that sets the step that is added on each match. A channel can also be forced to 32-bit compare, in which case only the low counter word takes part in the match and the match value wraps inside 32 bits. A legacy routing bit in the global configuration moves channel 0 and channel 1 onto two dedicated interrupt outputs and holds their normal outputs low.

Top module: `evt_timer`

## Requirements
- R1: After reset every configuration bit, the counter and all comparators read 0. Offset 0x000 reads a constant capability word: bits [12:8] hold the channel count minus one and bit 15 is 1 when legacy routing is supported (0x0000_8100 with two channels). Offset 0x004 reads the tick period in femtoseconds (parameter, default 4,000,000). Unmapped offsets read 0.
- R2: The global configuration at 0x010 has the run bit at bit 0. While it is 0 the counter holds its value and no channel pulses, even when the counter equals a match value.
- R3: While running, the counter increases by one per clock and carries from the low word into the high word. The low word at 0x0F0 and the high word at 0x0F4 are writable, and a write replaces the increment in that cycle. Writing 0 to both words clears the counter.
- R4: Channel n has its configuration at 0x100 + 0x20·n, its comparator low word at +0x08 and its comparator high word at +0x0C. Configuration bit 0 enables the interrupt, bit 1 selects periodic mode, bit 2 starts the load sequence and always reads 0, and bit 3 forces 32-bit compare.
- R5: After bit 2 is written as 1, the next comparator low-word write sets the match value and the following one sets the step, and the channel then returns to direct loading. A high-word write goes to the step while the step is awaited and to the match value otherwise.
- R6: In periodic mode, every cycle in which the counter equals the match value produces a pulse and advances the match value by the step. With the counter started from 0 and first match F, pulses appear F+1 cycles after the run bit is written and then every step cycles.
- R7: In one-shot mode a channel pulses once per comparator write. It stays silent if the counter meets the same value again, is re-armed by a new comparator write, and never pulses while its interrupt-enable bit is 0. The comparator value is unchanged by a one-shot match.
- R8: In 32-bit mode only the low counter word is compared, and a periodic advance wraps the low match word modulo 2^32 while leaving the high word unchanged.
- R9: With global bit 1 set, pulses of channel 0 and channel 1 appear on legacy_irq[0] and legacy_irq[1] instead of irq[0] and irq[1]. With it clear, legacy_irq stays 0.
- R10: Each interrupt pulse is one clock wide and is registered on the edge after the cycle in which the match is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (12) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | NUM_CH (2) | Per-channel interrupt pulses |
| legacy_irq | output | 2 | Routed pulses of channels 0 and 1 when legacy routing is on |

## Verification
A periodic channel is loaded with a first match that differs from its step (5 then 7). The pulse times show that the two sequence writes land in different places, and they also check the one-cycle latency. A one-shot channel is first run to its match. The counter is then rewound under it so that it meets the same value again, which separates a comparator that fires once from one that fires on every equality. The one-shot channel is then re-armed, and it is also armed with its interrupt-enable bit clear. The 32-bit case starts the counter with a nonzero high word and lets a periodic match wrap across 2^32, which shows whether the high word is ignored in the compare and kept in the advance. The match-while-stopped case and the legacy-routing case show whether the run bit and the routing bit gate the outputs.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
   localparam int unsigned REG_W     = 32;
   // register offsets (bytes)
   localparam int unsigned OFS_CAPS   = 'h000;
   localparam int unsigned OFS_TICK   = 'h004;
   localparam int unsigned OFS_GCFG   = 'h010;
   localparam int unsigned OFS_CNT_LO = 'h0F0;
   localparam int unsigned OFS_CNT_HI = 'h0F4;
   localparam int unsigned CH_BASE    = 'h100;
   localparam int unsigned CH_STRIDE  = 'h020;
   localparam int unsigned CH_CFG     = 'h000;
   localparam int unsigned CH_CMP_LO  = 'h008;
   localparam int unsigned CH_CMP_HI  = 'h00C;
   // bit positions
   localparam int unsigned GCFG_RUN   = 0;
   localparam int unsigned GCFG_LEG   = 1;
   localparam int unsigned CCFG_INT   = 0;
   localparam int unsigned CCFG_PER   = 1;
   localparam int unsigned CCFG_LOAD  = 2;
   localparam int unsigned CCFG_M32   = 3;
   localparam int unsigned CAPS_NUM_LSB = 8;
   localparam int unsigned CAPS_LEG_BIT = 15;

   typedef enum logic [1:0] {
      LD_IDLE  = 2'd0,
      LD_MATCH = 2'd1,
      LD_STEP  = 2'd2
   } load_state_e;
endpackage

// File: rtl/evt_timer_counter.sv
module evt_timer_counter
   import evt_timer_pkg::*;
#(
   parameter int unsigned CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [REG_W-1:0] wdata,
   output logic [CNT_W-1:0] count
);
   localparam int unsigned HALF = CNT_W / 2;

   generate
      if (HALF != REG_W) begin : g_bad_width
         $error("evt_timer_counter: CNT_W must be twice the bus width");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         count <= '0;
      end else if (wr_lo) begin
         count[HALF-1:0] <= wdata;
      end else if (wr_hi) begin
         count[CNT_W-1:HALF] <= wdata;
      end else if (run) begin
         count <= count + 1'b1;
      end
   end

   // R2: stopped counter holds its value
   assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (!run && !wr_lo && !wr_hi) |=> $stable(count));

   // R3: running counter steps by one
   assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
      (run && !wr_lo && !wr_hi) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/evt_timer_channel.sv
module evt_timer_channel
   import evt_timer_pkg::*;
#(
   parameter int unsigned CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             glb_run,
   input  logic [CNT_W-1:0] count,
   input  logic             cfg_we,
   input  logic             cmp_lo_we,
   input  logic             cmp_hi_we,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] cfg_rd,
   output logic [CNT_W-1:0] match_val,
   output logic             fire
);
   localparam int unsigned HALF = CNT_W / 2;

   logic             int_en, periodic, mode32, armed;
   load_state_e      ld_q;
   logic [CNT_W-1:0] cmp_q, step_q, advanced;
   logic             hit, any_cmp_we;

   assign any_cmp_we = cmp_lo_we | cmp_hi_we;
   assign match_val  = cmp_q;

   always_comb begin
      if (mode32) begin
         hit      = glb_run && (count[HALF-1:0] == cmp_q[HALF-1:0]);
         advanced = {cmp_q[CNT_W-1:HALF], cmp_q[HALF-1:0] + step_q[HALF-1:0]};
      end else begin
         hit      = glb_run && (count == cmp_q);
         advanced = cmp_q + step_q;
      end
   end

   always_comb begin
      cfg_rd           = '0;
      cfg_rd[CCFG_INT] = int_en;
      cfg_rd[CCFG_PER] = periodic;
      cfg_rd[CCFG_M32] = mode32;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         int_en   <= 1'b0;
         periodic <= 1'b0;
         mode32   <= 1'b0;
         armed    <= 1'b0;
         ld_q     <= LD_IDLE;
         cmp_q    <= '0;
         step_q   <= '0;
         fire     <= 1'b0;
      end else begin
         fire <= hit && int_en && (periodic || armed);
         if (cfg_we) begin
            int_en   <= wdata[CCFG_INT];
            periodic <= wdata[CCFG_PER];
            mode32   <= wdata[CCFG_M32];
            if (wdata[CCFG_LOAD]) ld_q <= LD_MATCH;
         end
         if (cmp_lo_we) begin
            armed <= 1'b1;
            case (ld_q)
               LD_MATCH: begin
                  cmp_q[HALF-1:0] <= wdata;
                  ld_q            <= LD_STEP;
               end
               LD_STEP: begin
                  step_q[HALF-1:0] <= wdata;
                  ld_q             <= LD_IDLE;
               end
               default: cmp_q[HALF-1:0] <= wdata;
            endcase
         end else if (cmp_hi_we) begin
            armed <= 1'b1;
            if (ld_q == LD_STEP) step_q[CNT_W-1:HALF] <= wdata;
            else                 cmp_q[CNT_W-1:HALF]  <= wdata;
         end else if (hit) begin
            if (periodic) cmp_q <= advanced;
            else          armed <= 1'b0;
         end
      end
   end

   // R2: nothing fires out of a stopped cycle
   assert_stopped_silent_R2: assert property (@(posedge clk) disable iff (rst)
      !glb_run |=> !fire);

   // R6: a periodic 64-bit match moves forward by the step
   assert_periodic_advance_R6: assert property (@(posedge clk) disable iff (rst)
      (hit && periodic && !mode32 && !any_cmp_we)
      |=> (match_val == $past(match_val) + $past(step_q)));

   // R8: 32-bit advance wraps in the low word, high word kept
   assert_wrap32_R8: assert property (@(posedge clk) disable iff (rst)
      (hit && periodic && mode32 && !any_cmp_we)
      |=> ((match_val[HALF-1:0] == $past(match_val[HALF-1:0]) + $past(step_q[HALF-1:0]))
           && $stable(match_val[CNT_W-1:HALF])));

   // R7: a one-shot pulse is not followed by a second one without a re-arm
   assert_oneshot_single_R7: assert property (@(posedge clk) disable iff (rst)
      (fire && !periodic && !$past(any_cmp_we) && !$past(cfg_we)) |=> !fire);
endmodule

// File: rtl/evt_timer.sv
module evt_timer
   import evt_timer_pkg::*;
#(
   parameter int unsigned NUM_CH     = 2,
   parameter int unsigned CNT_W      = 64,
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned TICK_FS    = 4000000,
   parameter bit          LEGACY_CAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   output logic [NUM_CH-1:0] irq,
   output logic [1:0]        legacy_irq
);
   localparam int unsigned HALF = CNT_W / 2;
   localparam logic [REG_W-1:0] CAPS_VAL =
      (REG_W'(NUM_CH - 1) << CAPS_NUM_LSB) | (REG_W'(LEGACY_CAP) << CAPS_LEG_BIT);

   generate
      if (NUM_CH < 2 || NUM_CH > 8) begin : g_bad_ch
         $error("evt_timer: NUM_CH must be between 2 and 8");
      end
      if ((CH_BASE + NUM_CH * CH_STRIDE) > (1 << ADDR_W)) begin : g_bad_addr
         $error("evt_timer: ADDR_W too small for the channel map");
      end
   endgenerate

   logic             run_q, leg_q;
   logic [CNT_W-1:0] count;
   logic [NUM_CH-1:0] cfg_we, lo_we, hi_we, fire;
   logic [REG_W-1:0] ch_cfg [NUM_CH];
   logic [CNT_W-1:0] ch_cmp [NUM_CH];
   logic [REG_W-1:0] rd_mux;

   // global configuration
   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= 1'b0;
         leg_q <= 1'b0;
      end else if (bus_wr && bus_addr == ADDR_W'(OFS_GCFG)) begin
         run_q <= bus_wdata[GCFG_RUN];
         leg_q <= bus_wdata[GCFG_LEG] & LEGACY_CAP;
      end
   end

   evt_timer_counter #(.CNT_W(CNT_W)) u_counter (
      .clk   (clk),
      .rst   (rst),
      .run   (run_q),
      .wr_lo (bus_wr && bus_addr == ADDR_W'(OFS_CNT_LO)),
      .wr_hi (bus_wr && bus_addr == ADDR_W'(OFS_CNT_HI)),
      .wdata (bus_wdata),
      .count (count)
   );

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         localparam int unsigned BASE = CH_BASE + i * CH_STRIDE;
         assign cfg_we[i] = bus_wr && (bus_addr == ADDR_W'(BASE + CH_CFG));
         assign lo_we[i]  = bus_wr && (bus_addr == ADDR_W'(BASE + CH_CMP_LO));
         assign hi_we[i]  = bus_wr && (bus_addr == ADDR_W'(BASE + CH_CMP_HI));

         evt_timer_channel #(.CNT_W(CNT_W)) u_channel (
            .clk       (clk),
            .rst       (rst),
            .glb_run   (run_q),
            .count     (count),
            .cfg_we    (cfg_we[i]),
            .cmp_lo_we (lo_we[i]),
            .cmp_hi_we (hi_we[i]),
            .wdata     (bus_wdata),
            .cfg_rd    (ch_cfg[i]),
            .match_val (ch_cmp[i]),
            .fire      (fire[i])
         );

         if (i < 2) begin : g_routed
            assign irq[i]        = fire[i] & ~leg_q;
            assign legacy_irq[i] = fire[i] &  leg_q;
         end else begin : g_plain
            assign irq[i] = fire[i];
         end
      end
   endgenerate

   // read path
   always_comb begin
      rd_mux = '0;
      if (bus_addr == ADDR_W'(OFS_CAPS))   rd_mux = CAPS_VAL;
      if (bus_addr == ADDR_W'(OFS_TICK))   rd_mux = REG_W'(TICK_FS);
      if (bus_addr == ADDR_W'(OFS_GCFG))   rd_mux = REG_W'({leg_q, run_q});
      if (bus_addr == ADDR_W'(OFS_CNT_LO)) rd_mux = count[HALF-1:0];
      if (bus_addr == ADDR_W'(OFS_CNT_HI)) rd_mux = count[CNT_W-1:HALF];
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_addr == ADDR_W'(CH_BASE + i * CH_STRIDE + CH_CFG))    rd_mux = ch_cfg[i];
         if (bus_addr == ADDR_W'(CH_BASE + i * CH_STRIDE + CH_CMP_LO)) rd_mux = ch_cmp[i][HALF-1:0];
         if (bus_addr == ADDR_W'(CH_BASE + i * CH_STRIDE + CH_CMP_HI)) rd_mux = ch_cmp[i][CNT_W-1:HALF];
      end
   end

   always_ff @(posedge clk) begin
      if (rst)         bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   // R9: routed channels keep their normal lines low
   assert_legacy_route_R9: assert property (@(posedge clk) disable iff (rst)
      (leg_q && fire[0]) |-> (legacy_irq[0] && !irq[0]));

   // R9: without routing the legacy lines stay quiet
   assert_legacy_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      !leg_q |-> (legacy_irq == 2'b00));
endmodule

// File: tb/evt_timer_tb.sv
`timescale 1ns/1ps
module evt_timer_tb;
   localparam int A_CAPS = 'h000, A_TICK = 'h004, A_GCFG = 'h010;
   localparam int A_CLO = 'h0F0, A_CHI = 'h0F4;
   localparam int A_C0CFG = 'h100, A_C0LO = 'h108, A_C0HI = 'h10C;
   localparam int A_C1CFG = 'h120, A_C1LO = 'h128, A_C1HI = 'h12C;

   logic        clk = 1'b0, rst = 1'b1;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [1:0]  irq, legacy_irq;

   evt_timer u_dut (
      .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .legacy_irq(legacy_irq)
   );

   always #2 clk = ~clk;

   int checks = 0, errors = 0, cyc = 0;
   bit done = 1'b0;
   always @(posedge clk) cyc <= cyc + 1;

   // pulse monitor: line 0 irq0, 1 irq1, 2 legacy0, 3 legacy1
   int   mon_cnt [4] = '{0, 0, 0, 0};
   int   mon_t [4][16];
   int   mon_wide = 0;
   logic [3:0] prev = '0;
   wire  [3:0] lines = {legacy_irq, irq};
   always @(negedge clk) begin
      for (int i = 0; i < 4; i++) begin
         if (lines[i] === 1'b1) begin
            mon_t[i][mon_cnt[i] % 16] <= cyc;
            mon_cnt[i] <= mon_cnt[i] + 1;
            if (prev[i] === 1'b1) mon_wide <= mon_wide + 1;
         end
      end
      prev <= lines;
   end

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d, output int t);
      bus_wr = 1'b1; bus_addr = 12'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      t = cyc;
   endtask

   task automatic wrq(input int a, input logic [31:0] d);
      int t;
      wr(a, d, t);
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = 12'(a);
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(A_CAPS, d);  chk("R1 caps word", d, 32'h0000_8100);
      rd(A_TICK, d);  chk("R1 tick period", d, 32'd4000000);
      rd(A_GCFG, d);  chk("R1 global cfg reset", d, 0);
      rd(A_CLO, d);   chk("R1 counter reset", d, 0);
      rd(A_C0CFG, d); chk("R1 channel cfg reset", d, 0);
      rd(A_C1LO, d);  chk("R1 comparator reset", d, 0);
      rd('h040, d);   chk("R1 unmapped read", d, 0);
      rd('h104, d);   chk("R1 unmapped channel hole", d, 0);
      chk("R1 no pulses after reset", mon_cnt[0] + mon_cnt[1] + mon_cnt[2] + mon_cnt[3], 0);
   endtask

   task automatic t_counter;
      logic [31:0] d;
      int n, m;
      wrq(A_GCFG, 0); wrq(A_CLO, 100); wrq(A_CHI, 2);
      idle(5);
      rd(A_CLO, d); chk("R2 stopped counter holds", d, 100);
      rd(A_CHI, d); chk("R3 high word write", d, 2);
      wr(A_GCFG, 1, n);
      idle(9);
      wr(A_GCFG, 0, m);
      rd(A_CLO, d); chk("R3 one step per clock", d, 100 + (m - n));
      idle(4);
      rd(A_CLO, d); chk("R2 hold after stop", d, 100 + (m - n));
      wrq(A_CLO, 0); wrq(A_CHI, 0);
      rd(A_CLO, d); chk("R3 clear low", d, 0);
      rd(A_CHI, d); chk("R3 clear high", d, 0);
   endtask

   task automatic t_periodic;
      logic [31:0] d;
      int n, c0, l0;
      wrq(A_GCFG, 0); wrq(A_CLO, 0); wrq(A_CHI, 0);
      wrq(A_C0CFG, 32'h7);            // int + periodic + load sequence
      wrq(A_C0LO, 5);                 // first match
      wrq(A_C0LO, 7);                 // step
      rd(A_C0CFG, d); chk("R4 load bit reads zero", d, 32'h3);
      rd(A_C0LO, d);  chk("R5 first write is match", d, 5);
      c0 = mon_cnt[0]; l0 = mon_cnt[2];
      wr(A_GCFG, 1, n);
      idle(24);
      wrq(A_GCFG, 0);
      chk("R6 periodic pulse count", mon_cnt[0] - c0, 3);
      chk("R10 first pulse one cycle after match", mon_t[0][c0 % 16], n + 6);
      chk("R5 second write is step", mon_t[0][(c0 + 1) % 16], n + 13);
      chk("R6 third pulse", mon_t[0][(c0 + 2) % 16], n + 20);
      rd(A_C0LO, d);  chk("R6 match advanced", d, 26);
      chk("R9 legacy quiet when not routed", mon_cnt[2] - l0, 0);
      chk("R10 single-cycle pulses", mon_wide, 0);
   endtask

   task automatic t_oneshot;
      logic [31:0] d, v;
      int n, w, e, c1;
      wrq(A_GCFG, 0); wrq(A_CLO, 0); wrq(A_CHI, 0);
      wrq(A_C1CFG, 32'h1); wrq(A_C1LO, 8);
      c1 = mon_cnt[1];
      wr(A_GCFG, 1, n);
      idle(12);
      chk("R7 one-shot fires", mon_cnt[1] - c1, 1);
      chk("R10 one-shot timing", mon_t[1][c1 % 16], n + 9);
      wr(A_CLO, 0, w);                // rewind under the channel
      idle(12);
      chk("R7 no second pulse on same value", mon_cnt[1] - c1, 1);
      wrq(A_C1LO, 20);                // re-arm, counter now below 20
      idle(10);
      chk("R7 re-armed pulse", mon_cnt[1] - c1, 2);
      chk("R7 re-armed timing", mon_t[1][(c1 + 1) % 16], w + 21);
      rd(A_C1LO, d); chk("R7 one-shot match unchanged", d, 20);
      wrq(A_C1CFG, 0); wrq(A_C1LO, 40);
      idle(30);
      chk("R7 silent with interrupt disabled", mon_cnt[1] - c1, 2);
      // equality while stopped
      wrq(A_GCFG, 0); wrq(A_C1CFG, 32'h1);
      rd(A_CLO, v);
      wrq(A_C1LO, v);
      idle(5);
      chk("R2 no pulse while stopped", mon_cnt[1] - c1, 2);
      wr(A_GCFG, 1, e);
      idle(3);
      wrq(A_GCFG, 0);
      chk("R2 pulse once running", mon_cnt[1] - c1, 3);
      chk("R2 pulse timing after start", mon_t[1][(c1 + 2) % 16], e + 1);
   endtask

   task automatic t_mode32;
      logic [31:0] d;
      int n, c0, c1;
      wrq(A_GCFG, 0); wrq(A_CLO, 0); wrq(A_CHI, 5);
      wrq(A_C1CFG, 32'h9); wrq(A_C1LO, 20); wrq(A_C1HI, 0);
      c1 = mon_cnt[1];
      wr(A_GCFG, 1, n);
      idle(25);
      wrq(A_GCFG, 0);
      chk("R8 low-word compare ignores high", mon_cnt[1] - c1, 1);
      chk("R8 low-word compare timing", mon_t[1][c1 % 16], n + 21);
      // periodic wrap across 2^32
      wrq(A_CLO, 32'hFFFF_FFE0); wrq(A_CHI, 0);
      wrq(A_C0CFG, 32'hF); wrq(A_C0LO, 32'hFFFF_FFF0); wrq(A_C0LO, 32'h20);
      c0 = mon_cnt[0];
      wr(A_GCFG, 1, n);
      idle(52);
      wrq(A_GCFG, 0);
      chk("R8 wrapped periodic count", mon_cnt[0] - c0, 2);
      chk("R8 first wrap pulse", mon_t[0][c0 % 16], n + 17);
      chk("R8 pulse after wrap", mon_t[0][(c0 + 1) % 16], n + 49);
      rd(A_C0LO, d); chk("R8 match wrapped low", d, 32'h30);
      rd(A_C0HI, d); chk("R8 match high kept", d, 0);
      rd(A_CHI, d);  chk("R3 carry into high word", d, 1);
   endtask

   task automatic t_legacy;
      int n, c0, c1, l0, l1;
      wrq(A_GCFG, 0); wrq(A_CLO, 0); wrq(A_CHI, 0);
      wrq(A_C0CFG, 32'h7); wrq(A_C0LO, 4); wrq(A_C0LO, 4);
      wrq(A_C1CFG, 32'h1); wrq(A_C1LO, 6);
      c0 = mon_cnt[0]; c1 = mon_cnt[1]; l0 = mon_cnt[2]; l1 = mon_cnt[3];
      wr(A_GCFG, 3, n);
      idle(10);
      wrq(A_GCFG, 0);
      chk("R9 channel 0 on legacy line", mon_cnt[2] - l0, 2);
      chk("R9 legacy 0 timing", mon_t[2][l0 % 16], n + 5);
      chk("R9 channel 1 on legacy line", mon_cnt[3] - l1, 1);
      chk("R9 legacy 1 timing", mon_t[3][l1 % 16], n + 7);
      chk("R9 normal lines held low", (mon_cnt[0] - c0) + (mon_cnt[1] - c1), 0);
      chk("R10 single-cycle pulses overall", mon_wide, 0);
   endtask

   initial begin
      idle(3);
      rst = 1'b0;
      idle(2);
      t_reset();
      t_counter();
      t_periodic();
      t_oneshot();
      t_mode32();
      t_legacy();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule